// File: doc/BRIEF.md
# Saturating Wronskian Ratio Element

This block forms the per-pixel change term used by a Wronskian change detector. Each cycle it may take one pixel of the current frame and the matching pixel of the previous frame, both 8-bit unsigned. It divides the current pixel by the previous one and keeps the quotient in unsigned fixed point with `FRAC_W` fractional bits (Q3.5 by default). It multiplies that quotient by itself, drops the low `DROP_W` bits of the product so the result is back on the quotient's scale, subtracts the quotient, and clamps the difference into 8 bits.

The datapath is all 8-bit unsigned, and every result that does not fit saturates instead of wrapping. With the default scaling, one output step is 1/32. A threshold between 0.6 and 0.7 then lands on codes 19 to 22, which keeps it resolvable by the 8-bit comparison done downstream. There are four registered stages: divide, multiply, truncate-and-subtract, clamp. A new pixel pair can enter every cycle. Window summation and thresholding are done by logic outside this block.

Top module: `wr_ratio_pe`

## Requirements
- R1: `res_vld` is high exactly four rising clock edges after an edge that sampled `px_vld` high, and is low in every other cycle.
- R2: Pixel pairs presented on consecutive cycles each produce their own result, in order, on consecutive cycles.
- R3: For a nonzero `px_prev`, the quotient is q = min(255, floor(`px_cur`·32 / `px_prev`)), and `res_term` = clamp(floor(q·q / 32) − q) into 0..255. Example: cur 50, prev 40 gives q 40 and a term of 10.
- R4: When the difference is negative, `res_term` is 0. This covers every pair with `px_cur` < `px_prev`.
- R5: When the difference exceeds 255, `res_term` is 255 and does not wrap. Example: cur 120, prev 30 gives q 128 and an unclamped value of 384.
- R6: When the exact ratio is 8 or more, the quotient saturates to 255, so `res_term` is 255.
- R7: When `px_prev` is 0, the quotient is 255 and `res_term` is 255, whatever `px_cur` is. This includes cur 0.
- R8: While `rst_n` is low, and after its release with no input yet, `res_vld` is 0 and `res_term` is 0.
- R9: `res_term` holds its last value in every cycle where `res_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| px_vld | input | 1 | Pixel pair valid |
| px_cur | input | 8 | Current-frame pixel (numerator) |
| px_prev | input | 8 | Previous-frame pixel (denominator) |
| res_vld | output | 1 | Result valid |
| res_term | output | 8 | Saturated term, Q3.5 scale |

## Verification
Two saturation points can act on the same pixel: the divider's quotient clamp and the final 8-bit clamp. A zero or very small denominator therefore fires both in a single result. The bench provokes this with a zero denominator and with ratios of 8 and above. It judges the output against a reference that applies each clamp on its own, and also checks a case where only the final clamp fires (ratio 4). A second coincidence is one result leaving while another pair enters on the same edge. This is exercised by long back-to-back streams, and every result is matched to its own entry cycle.

// File: rtl/wr_pkg.sv
package wr_pkg;
   typedef enum logic [0:0] {
      MUL_BOOTH  = 1'b0,
      MUL_DIRECT = 1'b1
   } mul_kind_e;
endpackage

// File: rtl/wr_div.sv
module wr_div #(
   parameter int PIX_W  = 8,
   parameter int FRAC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [PIX_W-1:0] num,
   input  logic [PIX_W-1:0] den,
   output logic             q_vld,
   output logic [PIX_W-1:0] q
);
   localparam int EXT_W = PIX_W + FRAC_W;

   logic [EXT_W-1:0]  ext;
   logic [PIX_W:0]    rem;
   logic [PIX_W-1:0]  quo;
   logic              sat;

   // restoring division, one quotient bit per conditional subtraction
   always_comb begin
      ext = {num, {FRAC_W{1'b0}}};
      rem = {{(PIX_W+1-FRAC_W){1'b0}}, ext[EXT_W-1:PIX_W]};
      sat = (den == '0) || (rem >= {1'b0, den});
      quo = '0;
      for (int i = PIX_W - 1; i >= 0; i--) begin
         rem = {rem[PIX_W-1:0], ext[i]};
         if (rem >= {1'b0, den}) begin
            rem    = rem - {1'b0, den};
            quo[i] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_vld <= 1'b0;
         q     <= '0;
      end else begin
         q_vld <= in_vld;
         if (in_vld) q <= sat ? {PIX_W{1'b1}} : quo;
      end
   end
endmodule

// File: rtl/wr_mul.sv
module wr_mul
   import wr_pkg::*;
#(
   parameter int        PIX_W = 8,
   parameter mul_kind_e KIND  = MUL_BOOTH
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_vld,
   input  logic [PIX_W-1:0]   q_in,
   output logic               p_vld,
   output logic [PIX_W-1:0]   q_out,
   output logic [2*PIX_W-1:0] prod
);
   localparam int PROD_W = 2 * PIX_W;
   localparam int ACC_W  = PROD_W + 2;

   logic [PROD_W-1:0] prod_c;

   generate
      if (KIND == MUL_BOOTH) begin : g_booth
         logic signed [ACC_W-1:0] acc;
         logic signed [ACC_W-1:0] mcand;
         logic [PIX_W+1:0]        mx;
         // radix-2 recoding of the zero-extended multiplier
         always_comb begin
            mcand = $signed({{(ACC_W-PIX_W){1'b0}}, q_in});
            mx    = {1'b0, q_in, 1'b0};
            acc   = '0;
            for (int i = 0; i <= PIX_W; i++) begin
               case (mx[i+:2])
                  2'b01:   acc = acc + (mcand <<< i);
                  2'b10:   acc = acc - (mcand <<< i);
                  default: acc = acc;
               endcase
            end
            prod_c = acc[PROD_W-1:0];
         end
      end else begin : g_direct
         always_comb prod_c = PROD_W'(q_in) * PROD_W'(q_in);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_vld <= 1'b0;
         q_out <= '0;
         prod  <= '0;
      end else begin
         p_vld <= in_vld;
         if (in_vld) begin
            q_out <= q_in;
            prod  <= prod_c;
         end
      end
   end
endmodule

// File: rtl/wr_trunc_sub.sv
module wr_trunc_sub #(
   parameter int PIX_W  = 8,
   parameter int DROP_W = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_vld,
   input  logic [2*PIX_W-1:0]            prod,
   input  logic [PIX_W-1:0]              q,
   output logic                          d_vld,
   output logic [2*PIX_W-DROP_W:0]       diff
);
   localparam int SQ_W = 2 * PIX_W - DROP_W;
   localparam int DW   = SQ_W + 1;

   logic [SQ_W-1:0] sq;
   logic [DW-1:0]   d_c;

   always_comb begin
      sq  = prod[2*PIX_W-1:DROP_W];
      d_c = {1'b0, sq} - {{(DW-PIX_W){1'b0}}, q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_vld <= 1'b0;
         diff  <= '0;
      end else begin
         d_vld <= in_vld;
         if (in_vld) diff <= d_c;
      end
   end
endmodule

// File: rtl/wr_ratio_pe.sv
module wr_ratio_pe
   import wr_pkg::*;
#(
   parameter int        PIX_W  = 8,
   parameter int        FRAC_W = 5,
   parameter int        DROP_W = 5,
   parameter mul_kind_e KIND   = MUL_BOOTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             px_vld,
   input  logic [PIX_W-1:0] px_cur,
   input  logic [PIX_W-1:0] px_prev,
   output logic             res_vld,
   output logic [PIX_W-1:0] res_term
);
   localparam int DW = 2 * PIX_W - DROP_W + 1;

   generate
      if (FRAC_W < 1 || FRAC_W >= PIX_W) begin : g_bad_frac
         $error("FRAC_W must lie in 1..PIX_W-1");
      end
      if (DROP_W < 1 || DROP_W >= PIX_W) begin : g_bad_drop
         $error("DROP_W must lie in 1..PIX_W-1");
      end
   endgenerate

   logic             s1_vld, s2_vld, s3_vld;
   logic [PIX_W-1:0] s1_q, s2_q;
   logic [2*PIX_W-1:0] s2_prod;
   logic [DW-1:0]    s3_diff;
   logic [PIX_W-1:0] clamp_c;

   wr_div #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_div (
      .clk(clk), .rst_n(rst_n), .in_vld(px_vld),
      .num(px_cur), .den(px_prev), .q_vld(s1_vld), .q(s1_q)
   );

   wr_mul #(.PIX_W(PIX_W), .KIND(KIND)) u_mul (
      .clk(clk), .rst_n(rst_n), .in_vld(s1_vld), .q_in(s1_q),
      .p_vld(s2_vld), .q_out(s2_q), .prod(s2_prod)
   );

   wr_trunc_sub #(.PIX_W(PIX_W), .DROP_W(DROP_W)) u_sub (
      .clk(clk), .rst_n(rst_n), .in_vld(s2_vld), .prod(s2_prod),
      .q(s2_q), .d_vld(s3_vld), .diff(s3_diff)
   );

   // stage 4: negative to zero, too large to all ones
   always_comb begin
      if (s3_diff[DW-1])                clamp_c = '0;
      else if (|s3_diff[DW-2:PIX_W])    clamp_c = {PIX_W{1'b1}};
      else                              clamp_c = s3_diff[PIX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld  <= 1'b0;
         res_term <= '0;
      end else begin
         res_vld <= s3_vld;
         if (s3_vld) res_term <= clamp_c;
      end
   end
endmodule

// File: rtl/wr_ratio_pe_chk.sv
module wr_ratio_pe_chk #(
   parameter int PIX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             px_vld,
   input logic [PIX_W-1:0] px_cur,
   input logic [PIX_W-1:0] px_prev,
   input logic             res_vld,
   input logic [PIX_W-1:0] res_term
);
   localparam logic [PIX_W-1:0] TOP = {PIX_W{1'b1}};

   logic [2:0] age;
   always_ff @(posedge clk) begin
      if (!rst_n)          age <= '0;
      else if (age != 3'd4) age <= age + 3'd1;
   end

   // R1
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 3'd4) |-> (res_vld == $past(px_vld, 4)));

   // R7
   zero_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 3'd4 && $past(px_vld, 4) && $past(px_prev, 4) == '0)
      |-> (res_term == TOP));

   // R4
   below_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 3'd4 && $past(px_vld, 4) && $past(px_cur, 4) < $past(px_prev, 4))
      |-> (res_term == '0));

   // R6
   big_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 3'd4 && $past(px_vld, 4) && $past(px_prev, 4) != '0 &&
       {3'b000, $past(px_cur, 4)} >= {$past(px_prev, 4), 3'b000})
      |-> (res_term == TOP));

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 3'd0 && !res_vld) |-> $stable(res_term));
endmodule

bind wr_ratio_pe wr_ratio_pe_chk #(.PIX_W(PIX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .px_vld(px_vld), .px_cur(px_cur),
   .px_prev(px_prev), .res_vld(res_vld), .res_term(res_term)
);

// File: tb/sim_wr_ratio_pe.sv
module sim_wr_ratio_pe;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       px_vld = 1'b0;
   logic [7:0] px_cur = '0;
   logic [7:0] px_prev = '0;
   logic       res_vld;
   logic [7:0] res_term;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct {
      int    term;
      int    due;
      string req;
   } item_t;
   item_t sb[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wr_ratio_pe u0 (
      .clk(clk), .rst_n(rst_n), .px_vld(px_vld), .px_cur(px_cur),
      .px_prev(px_prev), .res_vld(res_vld), .res_term(res_term)
   );

   function automatic int model(int c, int p);
      int q, d;
      if (p == 0) return 255;
      q = (c * 32) / p;
      if (q > 255) q = 255;
      d = (q * q) / 32 - q;
      if (d < 0)   return 0;
      if (d > 255) return 255;
      return d;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // driver: called just after a falling edge, holds for one cycle
   task automatic drive(int c, int p, string req);
      item_t it;
      px_vld  = 1'b1;
      px_cur  = 8'(c);
      px_prev = 8'(p);
      it.term = model(c, p);
      it.due  = cyc + 4;
      it.req  = req;
      sb.push_back(it);
      @(negedge clk);
      px_vld = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops expected results at the falling edge
   int last_term = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (res_vld) begin
            if (sb.size() == 0) begin
               check("R1 unexpected result", 1, 0);
            end else begin
               item_t it;
               it = sb.pop_front();
               check({it.req, " term"}, int'(res_term), it.term);
               check({it.req, " R1 cycle"}, cyc, it.due);
            end
            last_term = int'(res_term);
         end else begin
            if (sb.size() != 0 && sb[0].due <= cyc)
               check("R1 missing result", 0, 1);
            if (int'(res_term) != last_term)
               check("R9 hold", int'(res_term), last_term);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8 during reset
      check("R8 vld in reset", int'(res_vld), 0);
      check("R8 term in reset", int'(res_term), 0);
      rst_n = 1'b1;
      idle(3);
      check("R8 vld after release", int'(res_vld), 0);
      check("R8 term after release", int'(res_term), 0);

      drive(50, 40, "R3 50/40");
      idle(6);
      drive(100, 40, "R3 100/40");
      idle(2);
      drive(5, 3, "R3 5/3");
      idle(5);
      drive(40, 40, "R4 equal");
      drive(10, 100, "R4 below one");
      drive(0, 7, "R4 zero numerator");
      idle(3);
      drive(120, 30, "R5 term clamp");
      drive(200, 20, "R6 ratio 10");
      drive(64, 8, "R6 ratio 8");
      drive(63, 8, "R5 ratio below 8");
      drive(77, 0, "R7 zero den");
      drive(0, 0, "R7 zero over zero");
      idle(7);
      // R2 long back-to-back stream
      for (int c = 0; c < 256; c += 17)
         for (int p = 0; p < 256; p += 13)
            drive(c, p, "R2 stream");
      idle(3);
      // R9 mixed gaps
      for (int k = 1; k < 40; k++) begin
         drive((k * 37) % 256, (k * 11) % 256, "R9 gapped");
         idle(k % 3);
      end
      idle(10);
      check("R2 queue drained", sb.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule